// File: doc/BRIEF.md
# Registered Bidirectional Barrel Shifter

This block moves a 16-bit word left or right by any distance from 0 to 15 places. On each rising clock edge it captures the data word, the 4-bit distance, a direction flag and a signed-mode flag. The result is then formed from those held values alone. Callers see the result of the operands they presented at the previous edge.

The shift is built from one network of four cascaded stages, sized 1, 2, 4 and 8 places. Each stage is a row of 2:1 multiplexers, and the matching bit of the held distance enables it. Left shifts reuse the same right-shifting network: the word is mirrored on its way in and mirrored back on its way out. In signed mode a right shift copies the top bit into the emptied upper places. In every other case the emptied places are filled with zeros.

Top module: `bishift_top`

## Requirements
- R1: An active-high synchronous reset clears every operand register, so `dataOut` reads 0 after any clock edge at which `rst` is high.
- R2: `dataOut` depends only on the operands captured at the most recent rising edge; input changes between edges leave `dataOut` unchanged until the next edge.
- R3: A captured distance of 0 gives `dataOut` equal to the captured data word, for both directions and both sign modes.
- R4: With `goRight` = 1 the captured word moves toward bit 0 by `shiftAmt` places (0 to 15).
- R5: With `goRight` = 0 the captured word moves toward bit 15 by `shiftAmt` places, and the emptied low places are 0 whatever `signedMode` is.
- R6: With `goRight` = 1 and `signedMode` = 1, the emptied upper places and bit 15 of `dataOut` all equal bit 15 of the captured word.
- R7: With `goRight` = 1 and `signedMode` = 0, the emptied upper places are 0.
- R8: The total distance is the sum of the enabled stages, where distance bit k enables a move of 2^k places. Every distance from 0 to 15 therefore gives the exact shifted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 16 | Word to be shifted |
| shiftAmt | input | 4 | Shift distance, unsigned |
| goRight | input | 1 | 1: shift toward bit 0, 0: shift toward bit 15 |
| signedMode | input | 1 | 1: right shifts fill with bit 15, 0: fill with zeros |
| dataOut | output | 16 | Shifted result of the operands captured at the last edge |

## Verification
The only state in the block is its operand registers, and the network after them is combinational. A wrong held value or a stuck stage enable therefore shows at `dataOut` in the cycle right after the edge that captured the operands. A missing enable shows only for distances that use that stage. This is why every distance is applied in both directions and both sign modes, with operands whose top bit is set and operands whose top bit is clear. A fault in the mirroring or the fill logic shows as wrong bits in the emptied places. A fault in the capture path shows as an output that follows inputs changed in the middle of a cycle.

// File: rtl/bishift_pkg.sv
package bishift_pkg;

  localparam int unsigned DEF_DATA_W = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic mirror;     // shift toward MSB via bit reversal
    logic arithFill;  // right shift fills with the top bit
  } shfStrobe_t;

endpackage

// File: rtl/shf_mirror.sv
module shf_mirror #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             en,
  input  logic [WIDTH-1:0] inWord,
  output logic [WIDTH-1:0] outWord
);

  logic [WIDTH-1:0] flipped;

  for (genvar b = 0; b < WIDTH; b++) begin : g_flip
    assign flipped[b] = inWord[WIDTH-1-b];
  end

  assign outWord = en ? flipped : inWord;

endmodule

// File: rtl/shf_stage.sv
module shf_stage #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DIST  = 1
) (
  input  logic             en,
  input  logic             fill,
  input  logic [WIDTH-1:0] inWord,
  output logic [WIDTH-1:0] outWord
);

  // one 2:1 mux per bit; upper DIST bits take the fill value when moved
  for (genvar b = 0; b < WIDTH; b++) begin : g_mux
    if (b + DIST < WIDTH) begin : g_take
      assign outWord[b] = en ? inWord[b+DIST] : inWord[b];
    end else begin : g_fill
      assign outWord[b] = en ? fill : inWord[b];
    end
  end

endmodule

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import bishift_pkg::*;
#(
  parameter int unsigned AMT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic             goRight,
  input  logic             signedMode,
  output logic [AMT_W-1:0] stageEn,
  output shfStrobe_t       strobe
);

  logic [AMT_W-1:0] amtReg;
  logic             rightReg;
  logic             signReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      amtReg   <= '0;
      rightReg <= 1'b0;
      signReg  <= 1'b0;
    end else begin
      amtReg   <= shiftAmt;
      rightReg <= goRight;
      signReg  <= signedMode;
    end
  end

  assign stageEn          = amtReg;
  assign strobe.mirror    = ~rightReg;
  assign strobe.arithFill = rightReg & signReg;

endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
  import bishift_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned AMT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [AMT_W-1:0] stageEn,
  input  shfStrobe_t       strobe,
  output logic [WIDTH-1:0] dataOut
);

  logic [WIDTH-1:0] dataReg;
  logic [WIDTH-1:0] chain [AMT_W+1];
  logic             fillBit;

  always_ff @(posedge clk) begin
    if (rst) dataReg <= '0;
    else     dataReg <= dataIn;
  end

  assign fillBit = strobe.arithFill & dataReg[WIDTH-1];

  shf_mirror #(.WIDTH(WIDTH)) mirrorIn_i (
    .en(strobe.mirror), .inWord(dataReg), .outWord(chain[0])
  );

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    shf_stage #(.WIDTH(WIDTH), .DIST(1 << s)) stage_i (
      .en(stageEn[s]), .fill(fillBit),
      .inWord(chain[s]), .outWord(chain[s+1])
    );
  end

  shf_mirror #(.WIDTH(WIDTH)) mirrorOut_i (
    .en(strobe.mirror), .inWord(chain[AMT_W]), .outWord(dataOut)
  );

endmodule

// File: rtl/bishift_top.sv
module bishift_top
  import bishift_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_DATA_W,
  localparam int unsigned AMT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] dataIn,
  input  logic [AMT_W-1:0] shiftAmt,
  input  logic             goRight,
  input  logic             signedMode,
  output logic [WIDTH-1:0] dataOut
);

  logic [AMT_W-1:0] stageEn;
  shfStrobe_t       strobe;

  shf_ctrl #(.AMT_W(AMT_W)) ctrl_i (
    .clk(clk), .rst(rst), .shiftAmt(shiftAmt), .goRight(goRight),
    .signedMode(signedMode), .stageEn(stageEn), .strobe(strobe)
  );

  shf_datapath #(.WIDTH(WIDTH), .AMT_W(AMT_W)) dp_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .stageEn(stageEn),
    .strobe(strobe), .dataOut(dataOut)
  );

endmodule

// File: rtl/bishift_checker.sv
module bishift_checker #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned AMT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] dataIn,
  input logic [AMT_W-1:0] shiftAmt,
  input logic             goRight,
  input logic             signedMode,
  input logic [WIDTH-1:0] dataOut
);

  function automatic logic [WIDTH-1:0] lowMask(input logic [AMT_W-1:0] amt);
    return (WIDTH'(1) << amt) - WIDTH'(1);
  endfunction

  function automatic logic [WIDTH-1:0] highMask(input logic [AMT_W-1:0] amt);
    return ~({WIDTH{1'b1}} >> amt);
  endfunction

  logic rstSeen = 1'b0;
  always_ff @(posedge clk) rstSeen <= rst;

  // R1: output zero after a reset edge
  always @(negedge clk) begin
    if (rstSeen) assert_reset_zero_R1: assert (dataOut == '0);
  end

  // R3 / R2: zero distance passes the captured word
  assert_zero_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (shiftAmt == '0) |=> (dataOut == $past(dataIn)));

  // R5: left shift empties low bits to zero
  assert_left_lowzero_R5: assert property (@(posedge clk) disable iff (rst)
    !goRight |=> ((dataOut & lowMask($past(shiftAmt))) == '0));

  // R6: signed right shift keeps the top bit
  assert_sign_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (goRight && signedMode) |=> (dataOut[WIDTH-1] == $past(dataIn[WIDTH-1])));

  // R7: unsigned right shift empties high bits to zero
  assert_right_highzero_R7: assert property (@(posedge clk) disable iff (rst)
    (goRight && !signedMode) |=> ((dataOut & highMask($past(shiftAmt))) == '0));

endmodule

bind bishift_top bishift_checker #(.WIDTH(WIDTH), .AMT_W(AMT_W)) chk_i (
  .clk(clk), .rst(rst), .dataIn(dataIn), .shiftAmt(shiftAmt),
  .goRight(goRight), .signedMode(signedMode), .dataOut(dataOut)
);

// File: tb/bishift_top_tb_top.sv
`timescale 1ns/1ps
module bishift_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] dataIn = '0;
  logic [3:0]  shiftAmt = '0;
  logic        goRight = 1'b0;
  logic        signedMode = 1'b0;
  logic [15:0] dataOut;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bishift_top dut_i (
    .clk(clk), .rst(rst), .dataIn(dataIn), .shiftAmt(shiftAmt),
    .goRight(goRight), .signedMode(signedMode), .dataOut(dataOut)
  );

  function automatic logic [15:0] model(input logic [15:0] d, input logic [3:0] a,
                                        input logic r, input logic s);
    logic signed [15:0] sd;
    sd = $signed(d);
    if (!r)     return d << a;
    else if (s) return 16'(sd >>> a);
    else        return d >> a;
  endfunction

  function automatic string reqOf(input logic [3:0] a, input logic r, input logic s);
    if (a == 0) return "R3";
    if (!r)     return "R5";
    if (s)      return "R6";
    return "R7";
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: dataOut=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic runOne(input logic [15:0] d, input logic [3:0] a,
                        input logic r, input logic s, input string extra);
    logic [15:0] exp;
    @(negedge clk);
    dataIn = d; shiftAmt = a; goRight = r; signedMode = s;
    @(posedge clk);
    #1;
    exp = model(d, a, r, s);
    check({reqOf(a, r, s), extra}, dataOut, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd1234));

    // R1: reset clears output
    dataIn = 16'hBEEF; shiftAmt = 4'd0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset", dataOut, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    // R4 / R8: every distance, both directions and modes, both operand signs
    for (int a = 0; a < 16; a++) begin
      for (int m = 0; m < 4; m++) begin
        runOne(16'h8001, 4'(a), m[0], m[1], "/R8 neg");
        runOne(16'h7FF3, 4'(a), m[0], m[1], "/R8 pos");
      end
    end

    // R5: left shift ignores signed mode
    runOne(16'hFFFF, 4'd15, 1'b0, 1'b1, "/R5 sign ignored");
    runOne(16'hFFFF, 4'd7,  1'b0, 1'b1, "/R5 sign ignored");

    // R2: inputs changed mid-cycle do not move the output
    runOne(16'hC3A5, 4'd4, 1'b1, 1'b1, "/R2 capture");
    held = model(16'hC3A5, 4'd4, 1'b1, 1'b1);
    dataIn = 16'h1234; shiftAmt = 4'd9; goRight = 1'b0; signedMode = 1'b0;
    #1.5;
    check("R2 hold", dataOut, held);

    // R1: reset mid-run clears again
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1 mid reset", dataOut, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    // R4 / R8: random mix
    for (int i = 0; i < 400; i++) begin
      runOne(16'($urandom), 4'($urandom), 1'($urandom), 1'($urandom), "/R4 rand");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule